// File: doc/BRIEF.md
# CAN Fault Confinement and Error Interrupt Unit

This block keeps the fault-confinement state of a CAN-style node. A protocol engine outside it reports transmit and receive error events: an increment carries a weight (typically 8 or 1), a decrement is always 1. From these events the block maintains two saturating 8-bit error counters. From the counters it derives three status flags: warning, error-passive and bus-off. The warning threshold is programmable.

Status flags raise interrupts when they change, in either direction, not while they stay at a level. A third interrupt source reports every accepted bus error. Each bus error also offers an 8-bit capture word holding its type, direction and frame segment. That word stays frozen until the host acknowledges it with a read strobe. A host-driven recovery request brings the node back from bus-off with cleared counters.

Top module: `can_fault_state`

## Requirements
- R1: After reset both counters are 0, the warning limit is 96, all status flags, pending interrupts and the capture-valid flag are 0, and `irq` is 0.
- R2: `tx_inc` adds `tx_inc_amt` to the TX counter, and `tx_dec` subtracts 1, floored at 0. If both arrive in one cycle, only the increment applies. The RX counter behaves the same way with its own inputs, but it saturates at 255 instead of wrapping.
- R3: `warn_st` is 1 exactly when either counter is greater than or equal to the warning limit. A `lim_we` strobe loads `lim_wdata` as the new limit, and the new limit is readable on `err_limit` from the next cycle.
- R4: `passive_st` is 1 exactly when either counter is above 127.
- R5: A TX increment that would carry the counter past 255 sets `busoff_st` and leaves the TX counter at 255. While bus-off is set, counter events and bus errors are ignored. `rec_req` during bus-off clears bus-off and both counters. `rec_req` has no effect outside bus-off.
- R6: While `listen_only` is 1, RX increment and decrement events leave the RX counter unchanged.
- R7: `irq_pend[0]` (warning) is set one cycle after `warn_st` or `busoff_st` changes value in either direction, provided `ien[0]` is 1 in the cycle of the change.
- R8: `irq_pend[1]` (passive) is set one cycle after `passive_st` changes value in either direction, provided `ien[1]` is 1.
- R9: `irq_pend[2]` (bus error) is set one cycle after each accepted `berr_valid`, provided `ien[2]` is 1.
- R10: `irq_ack` clears all pending bits. A pending bit that is set in the same cycle as an acknowledge stays set. `irq` is the OR of the pending bits.
- R11: An accepted bus error loads `cap_word` = {type[1:0] in bits 7:6 (00 bit, 01 form, 10 stuff, 11 other), direction in bit 5 (1 receive, 0 transmit), segment in bits 4:0}. It sets `cap_valid`, but only if `cap_valid` is 0 or `cap_read` is high in the same cycle. Otherwise the word stays frozen. `cap_read` clears `cap_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| listen_only | input | 1 | Receive-only operation; freezes the RX counter |
| tx_inc | input | 1 | TX error increment event |
| tx_inc_amt | input | 4 | Weight of the TX increment |
| tx_dec | input | 1 | TX decrement-by-one event |
| rx_inc | input | 1 | RX error increment event |
| rx_inc_amt | input | 4 | Weight of the RX increment |
| rx_dec | input | 1 | RX decrement-by-one event |
| rec_req | input | 1 | Bus-off recovery request |
| lim_we | input | 1 | Warning limit write strobe |
| lim_wdata | input | 8 | New warning limit |
| berr_valid | input | 1 | Bus error detected |
| berr_type | input | 2 | Bus error type code |
| berr_rx | input | 1 | Bus error happened while receiving |
| berr_seg | input | 5 | Frame segment of the bus error |
| cap_read | input | 1 | Host read of the capture word |
| ien | input | 3 | Interrupt enables {bus error, passive, warning} |
| irq_ack | input | 1 | Clear all pending interrupts |
| tx_cnt | output | 8 | TX error counter |
| rx_cnt | output | 8 | RX error counter |
| err_limit | output | 8 | Current warning limit |
| warn_st | output | 1 | Warning status |
| passive_st | output | 1 | Error-passive status |
| busoff_st | output | 1 | Bus-off status |
| cap_word | output | 8 | Captured error code |
| cap_valid | output | 1 | Capture word holds an unread error |
| irq_pend | output | 3 | Pending interrupts {bus error, passive, warning} |
| irq | output | 1 | Interrupt request |

## Verification
The collisions that matter are these. A bus error can arrive in the same cycle as the host's capture read. An interrupt can be set in the same cycle as an acknowledge. A counter step that crosses the warning or passive threshold can come together with a bus error.

Directed sweeps cover several cases: the TX counter climbing in steps of 8 to bus-off, the RX counter saturating, the limit swept across its range, and every error type and direction. A long pseudo-random stretch then drives all strobes independently, so that every such pair lands together many times. After every clock, each output is compared against an arithmetic model built from the requirements. That model gives read-plus-capture the new word and gives set-plus-acknowledge a remaining pending bit.

// File: rtl/can_fault_state.sv
module can_fault_state #(
  parameter int unsigned LIMIT_RST  = 96,
  parameter int unsigned PASSIVE_TH = 127
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       listen_only,
  input  logic       tx_inc,
  input  logic [3:0] tx_inc_amt,
  input  logic       tx_dec,
  input  logic       rx_inc,
  input  logic [3:0] rx_inc_amt,
  input  logic       rx_dec,
  input  logic       rec_req,
  input  logic       lim_we,
  input  logic [7:0] lim_wdata,
  input  logic       berr_valid,
  input  logic [1:0] berr_type,
  input  logic       berr_rx,
  input  logic [4:0] berr_seg,
  input  logic       cap_read,
  input  logic [2:0] ien,
  input  logic       irq_ack,
  output logic [7:0] tx_cnt,
  output logic [7:0] rx_cnt,
  output logic [7:0] err_limit,
  output logic       warn_st,
  output logic       passive_st,
  output logic       busoff_st,
  output logic [7:0] cap_word,
  output logic       cap_valid,
  output logic [2:0] irq_pend,
  output logic       irq
);
  localparam logic [7:0] LIM0 = LIMIT_RST[7:0];
  localparam logic [7:0] PTH  = PASSIVE_TH[7:0];

  logic [7:0] tx_q, rx_q, lim_q, cap_q;
  logic       bo_q, cap_v_q;
  logic       w_prev, p_prev, b_prev;
  logic [2:0] pend_q;

  wire [8:0] tx_sum   = {1'b0, tx_q} + {5'b0, tx_inc_amt};
  wire [8:0] rx_sum   = {1'b0, rx_q} + {5'b0, rx_inc_amt};
  wire       berr_acc = berr_valid && !bo_q;
  wire       take_cap = berr_acc && (!cap_v_q || cap_read);

  assign warn_st    = (tx_q >= lim_q) || (rx_q >= lim_q);
  assign passive_st = (tx_q > PTH) || (rx_q > PTH);
  assign busoff_st  = bo_q;

  wire [2:0] set_v = {ien[2] && berr_acc,
                      ien[1] && (passive_st != p_prev),
                      ien[0] && ((warn_st != w_prev) || (bo_q != b_prev))};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
      bo_q <= 1'b0;
    end else if (bo_q) begin
      if (rec_req) begin
        tx_q <= '0;
        rx_q <= '0;
        bo_q <= 1'b0;
      end
    end else begin
      if (tx_inc) begin
        if (tx_sum[8]) begin
          tx_q <= 8'hFF;
          bo_q <= 1'b1;
        end else begin
          tx_q <= tx_sum[7:0];
        end
      end else if (tx_dec && tx_q != 8'd0) begin
        tx_q <= tx_q - 8'd1;
      end
      if (!listen_only) begin
        if (rx_inc)
          rx_q <= rx_sum[8] ? 8'hFF : rx_sum[7:0];
        else if (rx_dec && rx_q != 8'd0)
          rx_q <= rx_q - 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= LIM0;
      w_prev  <= 1'b0;
      p_prev  <= 1'b0;
      b_prev  <= 1'b0;
      pend_q  <= '0;
      cap_q   <= '0;
      cap_v_q <= 1'b0;
    end else begin
      if (lim_we) lim_q <= lim_wdata;
      w_prev <= warn_st;
      p_prev <= passive_st;
      b_prev <= bo_q;
      pend_q <= (irq_ack ? 3'b000 : pend_q) | set_v;
      if (take_cap) begin
        cap_q   <= {berr_type, berr_rx, berr_seg};
        cap_v_q <= 1'b1;
      end else if (cap_read) begin
        cap_v_q <= 1'b0;
      end
    end
  end

  assign tx_cnt    = tx_q;
  assign rx_cnt    = rx_q;
  assign err_limit = lim_q;
  assign cap_word  = cap_q;
  assign cap_valid = cap_v_q;
  assign irq_pend  = pend_q;
  assign irq       = |pend_q;

  assert_rx_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= 8'd240 && rx_inc && !listen_only && !busoff_st) |=> rx_cnt >= 8'd240);

  assert_busoff_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busoff_st) |-> (tx_cnt == 8'hFF && $past(tx_inc)));

  assert_listen_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (listen_only && !busoff_st) |=> $stable(rx_cnt));

  assert_warn_edge_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((warn_st != $past(warn_st)) && ien[0]) |=> irq_pend[0]);

  assert_passive_edge_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((passive_st != $past(passive_st)) && ien[1]) |=> irq_pend[1]);

  assert_berr_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_valid && !busoff_st && ien[2]) |=> irq_pend[2]);

  assert_cap_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_read) |=> ($stable(cap_word) && cap_valid));
endmodule

// File: tb/sim_can_fault_state.sv
`timescale 1ns/1ps
module sim_can_fault_state;
  logic clk = 1'b0, rst_n = 1'b0;
  logic listen_only = 0, tx_inc = 0, tx_dec = 0, rx_inc = 0, rx_dec = 0;
  logic [3:0] tx_inc_amt = 0, rx_inc_amt = 0;
  logic rec_req = 0, lim_we = 0, berr_valid = 0, berr_rx = 0, cap_read = 0, irq_ack = 0;
  logic [7:0] lim_wdata = 0;
  logic [1:0] berr_type = 0;
  logic [4:0] berr_seg = 0;
  logic [2:0] ien = 0;
  logic [7:0] tx_cnt, rx_cnt, err_limit, cap_word;
  logic warn_st, passive_st, busoff_st, cap_valid, irq;
  logic [2:0] irq_pend;

  int n_cmp = 0, n_bad = 0;
  int m_tx, m_rx, m_lim;
  bit m_bo, m_pw, m_pp, m_pb, m_cv;
  bit [2:0] m_pend;
  int m_cw;
  logic [31:0] lfsr = 32'h1ACE_2B3D;

  can_fault_state u0 (.*);

  always #4 clk = ~clk;

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 tx counter", tx_cnt, m_tx);
    chk("R6 rx counter", rx_cnt, m_rx);
    chk("R3 limit", err_limit, m_lim);
    chk("R3 warning status", warn_st, (m_tx >= m_lim || m_rx >= m_lim));
    chk("R4 passive status", passive_st, (m_tx > 127 || m_rx > 127));
    chk("R5 bus-off status", busoff_st, m_bo);
    chk("R7 warning pending", irq_pend[0], m_pend[0]);
    chk("R8 passive pending", irq_pend[1], m_pend[1]);
    chk("R9 bus error pending", irq_pend[2], m_pend[2]);
    chk("R10 irq line", irq, |m_pend);
    chk("R11 capture valid", cap_valid, m_cv);
    chk("R11 capture word", cap_word, m_cw);
  endtask

  task automatic model();
    bit cw, cp, acc;
    cw = (m_tx >= m_lim || m_rx >= m_lim);
    cp = (m_tx > 127 || m_rx > 127);
    acc = berr_valid && !m_bo;
    if (irq_ack) m_pend = 3'b000;
    if (ien[0] && (cw != m_pw || m_bo != m_pb)) m_pend[0] = 1;
    if (ien[1] && cp != m_pp) m_pend[1] = 1;
    if (ien[2] && acc) m_pend[2] = 1;
    m_pw = cw; m_pp = cp; m_pb = m_bo;
    if (acc && (!m_cv || cap_read)) begin
      m_cw = berr_type * 64 + berr_rx * 32 + berr_seg;
      m_cv = 1;
    end else if (cap_read) m_cv = 0;
    if (lim_we) m_lim = lim_wdata;
    if (m_bo) begin
      if (rec_req) begin m_tx = 0; m_rx = 0; m_bo = 0; end
    end else begin
      if (tx_inc) begin
        if (m_tx + tx_inc_amt > 255) begin m_tx = 255; m_bo = 1; end
        else m_tx = m_tx + tx_inc_amt;
      end else if (tx_dec && m_tx > 0) m_tx = m_tx - 1;
      if (!listen_only) begin
        if (rx_inc) m_rx = (m_rx + rx_inc_amt > 255) ? 255 : m_rx + rx_inc_amt;
        else if (rx_dec && m_rx > 0) m_rx = m_rx - 1;
      end
    end
  endtask

  task automatic step();
    model();
    @(posedge clk);
    #1;
    compare_all();
    tx_inc = 0; tx_dec = 0; rx_inc = 0; rx_dec = 0; rec_req = 0;
    lim_we = 0; berr_valid = 0; cap_read = 0; irq_ack = 0;
  endtask

  initial begin
    m_tx = 0; m_rx = 0; m_lim = 96; m_bo = 0; m_pw = 0; m_pp = 0; m_pb = 0;
    m_cv = 0; m_pend = 0; m_cw = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset tx", tx_cnt, 0);
    chk("R1 reset limit", err_limit, 96);
    chk("R1 reset status", {warn_st, passive_st, busoff_st, cap_valid, irq}, 0);
    chk("R1 reset pending", irq_pend, 0);

    ien = 3'b111;
    for (int i = 0; i < 33; i++) begin
      tx_inc = 1; tx_inc_amt = 8; tx_dec = (i % 3 == 0);
      if (i % 5 == 4) irq_ack = 1;
      step();
    end
    berr_valid = 1; step();
    rec_req = 1; step();
    rec_req = 1; tx_inc = 1; tx_inc_amt = 4; step();
    tx_dec = 1; step(); tx_dec = 1; step(); tx_dec = 1; step();

    listen_only = 1;
    rx_inc = 1; rx_inc_amt = 15; step();
    rx_dec = 1; step();
    listen_only = 0;
    for (int i = 0; i < 20; i++) begin
      rx_inc = 1; rx_inc_amt = 15; irq_ack = (i == 10); step();
    end
    for (int v = 0; v < 256; v += 15) begin
      lim_we = 1; lim_wdata = v[7:0]; irq_ack = 1; step(); step();
    end
    for (int i = 0; i < 40; i++) begin
      rx_dec = 1; step();
    end

    ien = 3'b100;
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 32; s += 13) begin
          berr_valid = 1; berr_type = t[1:0]; berr_rx = d[0]; berr_seg = s[4:0];
          cap_read = (s == 26); irq_ack = (s == 13);
          step();
          cap_read = (d == 1); step();
        end
    berr_valid = 1; berr_type = 2'd2; berr_seg = 5'd9; step();
    berr_valid = 1; berr_type = 2'd1; berr_seg = 5'd3; cap_read = 1; step();

    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tx_inc = (lfsr[3:0] < 3); tx_inc_amt = lfsr[7:4];
      tx_dec = (lfsr[11:8] < 7);
      rx_inc = (lfsr[14:12] < 2); rx_inc_amt = lfsr[18:15];
      rx_dec = (lfsr[21:19] < 4);
      rec_req = (lfsr[24:22] == 0);
      berr_valid = (lfsr[26:25] == 0); berr_type = lfsr[28:27];
      berr_rx = lfsr[29]; berr_seg = lfsr[9:5];
      cap_read = (lfsr[31:30] == 0);
      irq_ack = (lfsr[2:0] == 3'd5);
      lim_we = (lfsr[13:8] == 6'd0); lim_wdata = lfsr[23:16];
      if (i % 97 == 0) listen_only = lfsr[10];
      if (i % 61 == 0) ien = lfsr[20:18];
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule